// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel

This block is one channel of a DMA engine. It moves 32-bit words from a fixed peripheral data register into consecutive words of data memory. Each word starts when the peripheral raises its request line, which means its data buffer holds a word. The channel then runs two request/grant handshakes with separate arbiters. First it asks for the peripheral bus and reads the word into an internal holding register. Then it asks for the data memory and writes the held word at the current destination address.

Software programs a word count, a destination base address, the source register address, a linear or circular mode, and a mask for four interrupt flags: start, counter, complete and disabled. It then raises the enable input. In linear mode the channel stops in a complete state after the programmed number of words. In circular mode it wraps back to the base address and keeps running.

Enable can be lowered at any time. If a word is already in progress, that word is finished before the channel goes idle. If the channel is only waiting for a request, it goes idle on the next cycle. In both cases the disabled flag reports the stop.

Top module: `p2m_dma_channel`

## Requirements
- R1: After reset the status state is idle (0), no bus request is raised, all four flags are clear and the word count is 0.
- R2: On enable in the idle state, the channel sets the start flag (bit 0) and the status state becomes active (1). With a programmed length of 0, it goes instead straight to complete (2) and sets the complete flag (bit 2), without any bus request.
- R3: While active, a word starts only on `periph_req`. The peripheral bus request stays high until granted and presents the fixed source address.
- R4: `periph_ack` is a one-cycle pulse in the cycle after the peripheral-bus grant, while the memory write is still pending.
- R5: The memory request carries the word read from the peripheral and the address base + 4·n for word n. Address and data stay stable until the grant.
- R6: Each granted memory write increments the word count and sets the counter flag (bit 1).
- R7: In linear mode the last word moves the status to complete (2), leaves the count equal to the length and sets the complete flag. No further bus request is made until the channel is disabled.
- R8: In circular mode the last word resets the count to 0, makes the next address the base, sets the complete flag, and keeps the status active.
- R9: If enable falls after a word has started, that word still completes its write. The channel then goes idle with the disabled flag (bit 3) set, and later peripheral requests are ignored.
- R10: If enable falls while the channel waits for a request, or while it is complete, the status is idle on the next cycle and the disabled flag is set, without any further peripheral request.
- R11: A flag is set only if its bit in `irq_en` is 1. Writing 1 to a bit of `flag_clr` clears that flag alone; a new event in the same cycle wins over the clear.
- R12: The peripheral bus and the memory are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Channel enable level |
| cfg_circular | input | 1 | 1 = circular mode, 0 = linear |
| cfg_len | input | LW | Words per pass |
| cfg_src_addr | input | AW | Peripheral data register address |
| cfg_dst_base | input | AW | Destination base address |
| irq_en | input | 4 | Flag enables: {disabled, complete, counter, start} |
| flag_clr | input | 4 | Write-1-to-clear pulses, same bit order |
| periph_req | input | 1 | Peripheral has a word ready |
| periph_ack | output | 1 | Word taken from the peripheral |
| pbus_req | output | 1 | Peripheral bus request |
| pbus_gnt | input | 1 | Peripheral bus grant; read data valid |
| pbus_addr | output | AW | Peripheral read address |
| pbus_rdata | input | DW | Peripheral read data |
| mem_req | output | 1 | Data memory write request |
| mem_gnt | input | 1 | Data memory grant; write taken |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| status_state | output | 2 | 0 idle, 1 active, 2 complete |
| status_flags | output | 4 | Sticky flags: {disabled, complete, counter, start} |
| irq | output | 1 | OR of all flags |
| xfer_count | output | LW | Words written in the current pass |

## Verification
The assertions check the handshake rules on every cycle. A request is held until it is granted, the two arbiters are never asked at once, and the write address and data stay stable while waiting. The acknowledge pulse follows only a peripheral grant. The idle and complete states are quiet on both buses, and a disable while waiting reaches idle on the next cycle. Only the bench scenarios can show the data path and the counting: the word and address written for each index, the count after each write, the wrap in circular mode, a disable that lets the word in flight finish, and flag masking and clearing.

// File: rtl/p2m_dma_pkg.sv
package p2m_dma_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_WAIT = 3'd1,
        SQ_PBUS = 3'd2,
        SQ_MEM  = 3'd3,
        SQ_DONE = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_ACTIVE   = 2'd1,
        CH_COMPLETE = 2'd2
    } chan_status_e;

    localparam int unsigned NUM_FLAGS  = 4;
    localparam int unsigned FLAG_START = 0;
    localparam int unsigned FLAG_COUNT = 1;
    localparam int unsigned FLAG_DONE  = 2;
    localparam int unsigned FLAG_OFF   = 3;

endpackage

// File: rtl/p2m_dma_seq.sv
module p2m_dma_seq
    import p2m_dma_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 circular,
    input  logic                 zero_len,
    input  logic                 last_word,
    input  logic                 periph_req,
    input  logic                 pbus_gnt,
    input  logic [DW-1:0]        pbus_rdata,
    input  logic                 mem_gnt,
    output logic                 pbus_req,
    output logic                 mem_req,
    output logic                 periph_ack,
    output logic [DW-1:0]        hold_word,
    output logic                 cnt_load,
    output logic                 cnt_adv,
    output logic [NUM_FLAGS-1:0] evt,
    output logic [1:0]           status
);

    typedef struct packed {
        seq_state_e    st;
        logic          abort;
        logic          ack;
        logic [DW-1:0] hold;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      abort_now;

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        cnt_load  = 1'b0;
        cnt_adv   = 1'b0;
        evt       = '0;
        abort_now = q.abort | ~enable;
        unique case (q.st)
            SQ_IDLE: begin
                if (enable) begin
                    evt[FLAG_START] = 1'b1;
                    cnt_load        = 1'b1;
                    d.abort         = 1'b0;
                    if (zero_len) begin
                        d.st           = SQ_DONE;
                        evt[FLAG_DONE] = 1'b1;
                    end else begin
                        d.st = SQ_WAIT;
                    end
                end
            end
            SQ_WAIT: begin
                if (!enable) begin
                    d.st          = SQ_IDLE;
                    evt[FLAG_OFF] = 1'b1;
                end else if (periph_req) begin
                    d.st = SQ_PBUS;
                end
            end
            SQ_PBUS: begin
                d.abort = abort_now;
                if (pbus_gnt) begin
                    d.hold = pbus_rdata;
                    d.ack  = 1'b1;
                    d.st   = SQ_MEM;
                end
            end
            SQ_MEM: begin
                d.abort = abort_now;
                if (mem_gnt) begin
                    cnt_adv         = 1'b1;
                    evt[FLAG_COUNT] = 1'b1;
                    if (last_word) begin
                        evt[FLAG_DONE] = 1'b1;
                        d.st           = circular ? SQ_WAIT : SQ_DONE;
                    end else begin
                        d.st = SQ_WAIT;
                    end
                    if (abort_now) begin
                        d.st          = SQ_IDLE;
                        d.abort       = 1'b0;
                        evt[FLAG_OFF] = 1'b1;
                    end
                end
            end
            SQ_DONE: begin
                if (!enable) begin
                    d.st          = SQ_IDLE;
                    evt[FLAG_OFF] = 1'b1;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, abort: 1'b0, ack: 1'b0, hold: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            SQ_IDLE: status = CH_IDLE;
            SQ_DONE: status = CH_COMPLETE;
            default: status = CH_ACTIVE;
        endcase
    end

    assign pbus_req   = (q.st == SQ_PBUS);
    assign mem_req    = (q.st == SQ_MEM);
    assign periph_ack = q.ack;
    assign hold_word  = q.hold;

endmodule

// File: rtl/p2m_dma_addr.sv
module p2m_dma_addr #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          circular,
    input  logic [LW-1:0] cfg_len,
    input  logic [AW-1:0] dst_base,
    output logic [AW-1:0] dst_addr,
    output logic [LW-1:0] count,
    output logic          last_word,
    output logic          zero_len
);

    localparam int unsigned STEP = DW / 8;

    typedef struct packed {
        logic [LW-1:0] cnt;
        logic [AW-1:0] dst;
    } addr_regs_t;

    addr_regs_t q, d;
    logic [LW:0] cnt_next;

    always_comb begin
        d         = q;
        cnt_next  = {1'b0, q.cnt} + {{LW{1'b0}}, 1'b1};
        last_word = (cnt_next == {1'b0, cfg_len});
        zero_len  = (cfg_len == '0);
        if (load) begin
            d.cnt = '0;
            d.dst = dst_base;
        end else if (adv) begin
            if (last_word && circular) begin
                d.cnt = '0;
                d.dst = dst_base;
            end else begin
                d.cnt = cnt_next[LW-1:0];
                d.dst = q.dst + AW'(STEP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, dst: '0};
        end else begin
            q <= d;
        end
    end

    assign dst_addr = q.dst;
    assign count    = q.cnt;

endmodule

// File: rtl/p2m_dma_flags.sv
module p2m_dma_flags #(
    parameter int unsigned NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] evt,
    input  logic [NF-1:0] en,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);

    logic [NF-1:0] flags_q, flags_d;

    always_comb begin
        for (int i = 0; i < NF; i++) begin
            flags_d[i] = (flags_q[i] & ~clr[i]) | (evt[i] & en[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/p2m_dma_channel.sv
module p2m_dma_channel
    import p2m_dma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic                 cfg_circular,
    input  logic [LW-1:0]        cfg_len,
    input  logic [AW-1:0]        cfg_src_addr,
    input  logic [AW-1:0]        cfg_dst_base,
    input  logic [NUM_FLAGS-1:0] irq_en,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic                 periph_req,
    output logic                 periph_ack,
    output logic                 pbus_req,
    input  logic                 pbus_gnt,
    output logic [AW-1:0]        pbus_addr,
    input  logic [DW-1:0]        pbus_rdata,
    output logic                 mem_req,
    input  logic                 mem_gnt,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic [1:0]           status_state,
    output logic [NUM_FLAGS-1:0] status_flags,
    output logic                 irq,
    output logic [LW-1:0]        xfer_count
);

    logic                 cnt_load;
    logic                 cnt_adv;
    logic                 last_word;
    logic                 zero_len;
    logic [NUM_FLAGS-1:0] evt;

    p2m_dma_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .circular   (cfg_circular),
        .zero_len   (zero_len),
        .last_word  (last_word),
        .periph_req (periph_req),
        .pbus_gnt   (pbus_gnt),
        .pbus_rdata (pbus_rdata),
        .mem_gnt    (mem_gnt),
        .pbus_req   (pbus_req),
        .mem_req    (mem_req),
        .periph_ack (periph_ack),
        .hold_word  (mem_wdata),
        .cnt_load   (cnt_load),
        .cnt_adv    (cnt_adv),
        .evt        (evt),
        .status     (status_state)
    );

    p2m_dma_addr #(.AW(AW), .DW(DW), .LW(LW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .adv       (cnt_adv),
        .circular  (cfg_circular),
        .cfg_len   (cfg_len),
        .dst_base  (cfg_dst_base),
        .dst_addr  (mem_addr),
        .count     (xfer_count),
        .last_word (last_word),
        .zero_len  (zero_len)
    );

    p2m_dma_flags #(.NF(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .en    (irq_en),
        .clr   (flag_clr),
        .flags (status_flags)
    );

    assign pbus_addr = cfg_src_addr;
    assign irq       = |status_flags;

endmodule

// File: rtl/p2m_dma_checker.sv
module p2m_dma_checker #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          periph_ack,
    input logic          pbus_req,
    input logic          pbus_gnt,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [1:0]    status_state
);

    a_r12_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(pbus_req && mem_req));

    a_r3_pbus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_req && !pbus_gnt |=> pbus_req);

    a_r4_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> $past(pbus_req && pbus_gnt));

    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> mem_req ##1 !periph_ack);

    a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status_state != 2'd3);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        status_state == 2'd0 |-> !pbus_req && !mem_req);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        status_state == 2'd2 |-> !pbus_req && !mem_req);

    a_r10_wait_disable: assert property (@(posedge clk) disable iff (!rst_n)
        status_state == 2'd1 && !pbus_req && !mem_req && !cfg_enable |=> status_state == 2'd0);

endmodule

bind p2m_dma_channel p2m_dma_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .periph_ack   (periph_ack),
    .pbus_req     (pbus_req),
    .pbus_gnt     (pbus_gnt),
    .mem_req      (mem_req),
    .mem_gnt      (mem_gnt),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .status_state (status_state)
);

// File: tb/tb_p2m_dma_channel.sv
module tb_p2m_dma_channel;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam logic [AW-1:0] SRC  = 32'h4000_0010;
    localparam logic [AW-1:0] BASE = 32'h2000_0100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_enable, cfg_circular;
    logic [LW-1:0] cfg_len;
    logic [3:0]    irq_en, flag_clr;
    logic          periph_req, periph_ack;
    logic          pbus_req, pbus_gnt;
    logic [AW-1:0] pbus_addr;
    logic [DW-1:0] pbus_rdata;
    logic          mem_req, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [1:0]    status_state;
    logic [3:0]    status_flags;
    logic          irq;
    logic [LW-1:0] xfer_count;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    p2m_dma_channel #(.AW(AW), .DW(DW), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_circular(cfg_circular),
        .cfg_len(cfg_len), .cfg_src_addr(SRC), .cfg_dst_base(BASE), .irq_en(irq_en),
        .flag_clr(flag_clr), .periph_req(periph_req), .periph_ack(periph_ack),
        .pbus_req(pbus_req), .pbus_gnt(pbus_gnt), .pbus_addr(pbus_addr),
        .pbus_rdata(pbus_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .status_state(status_state),
        .status_flags(status_flags), .irq(irq), .xfer_count(xfer_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        flag_clr = 4'hF;
        step();
        flag_clr = 4'h0;
        chk("R11 clear all flags", status_flags, 4'h0);
    endtask

    // One word: request, peripheral grant after pd waits, memory grant after md waits.
    task automatic do_word(input logic [DW-1:0] data, input logic [AW-1:0] exp_addr,
                           input int pd, input int md, input bit drop_en);
        int guard;
        periph_req = 1'b1;
        guard = 0;
        step();
        while (!pbus_req && guard < 20) begin
            step();
            guard++;
        end
        chk("R3 pbus request", pbus_req, 1'b1);
        chk("R3 source address", pbus_addr, SRC);
        if (drop_en) cfg_enable = 1'b0;
        for (int k = 0; k < pd; k++) begin
            step();
            chk("R3 pbus held", pbus_req, 1'b1);
            chk("R12 no mem during read", mem_req, 1'b0);
        end
        pbus_gnt   = 1'b1;
        pbus_rdata = data;
        step();
        pbus_gnt   = 1'b0;
        pbus_rdata = '0;
        periph_req = 1'b0;
        chk("R4 ack pulse", periph_ack, 1'b1);
        chk("R12 pbus released", pbus_req, 1'b0);
        chk("R5 mem request", mem_req, 1'b1);
        chk("R5 mem address", mem_addr, exp_addr);
        chk("R5 mem data", mem_wdata, data);
        for (int k = 0; k < md; k++) begin
            step();
            chk("R4 ack single cycle", periph_ack, 1'b0);
            chk("R5 mem held", {mem_req, mem_addr, mem_wdata[27:0]}, {1'b1, exp_addr, data[27:0]});
        end
        mem_gnt = 1'b1;
        step();
        mem_gnt = 1'b0;
        chk("R5 mem released", mem_req, 1'b0);
    endtask

    initial begin
        int wd;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_circular = 1'b0; cfg_len = '0;
        irq_en = 4'hF; flag_clr = 4'h0; periph_req = 1'b0;
        pbus_gnt = 1'b0; pbus_rdata = '0; mem_gnt = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset state", status_state, 2'd0);
        chk("R1 reset flags", status_flags, 4'h0);
        chk("R1 reset requests", {pbus_req, mem_req, periph_ack}, 3'b000);
        chk("R1 reset count", xfer_count, 0);

        // Linear sweep over lengths 0..4 with varying grant delays
        for (int L = 0; L <= 4; L++) begin
            cfg_len = LW'(L); cfg_circular = 1'b0; cfg_enable = 1'b1;
            step();
            if (L == 0) begin
                chk("R2 zero length complete", status_state, 2'd2);
                chk("R2 zero length flags", status_flags, 4'b0101);
                chk("R2 zero length no bus", {pbus_req, mem_req}, 2'b00);
            end else begin
                chk("R2 start active", status_state, 2'd1);
                chk("R2 start flag", status_flags, 4'b0001);
            end
            for (int i = 0; i < L; i++) begin
                do_word(32'hA500_0000 + 32'(L * 16 + i), BASE + AW'(4 * i), i % 3, (i + L) % 2, 1'b0);
                chk("R6 count after write", xfer_count, i + 1);
                chk("R6 counter flag", status_flags[1], 1'b1);
            end
            if (L > 0) begin
                chk("R7 linear complete", status_state, 2'd2);
                chk("R7 final count", xfer_count, L);
                chk("R7 complete flag", status_flags[2], 1'b1);
                periph_req = 1'b1;
                repeat (3) step();
                chk("R7 no request when complete", pbus_req, 1'b0);
                periph_req = 1'b0;
            end
            cfg_enable = 1'b0;
            step();
            chk("R10 disable from complete", status_state, 2'd0);
            chk("R10 disabled flag", status_flags[3], 1'b1);
            clear_all();
        end

        // Circular: length 3, seven words
        cfg_len = 8'd3; cfg_circular = 1'b1; cfg_enable = 1'b1;
        step();
        clear_all();
        for (int i = 0; i < 7; i++) begin
            do_word(32'h5A00_0000 + 32'(i), BASE + AW'(4 * (i % 3)), (i + 1) % 2, i % 2, 1'b0);
            chk("R8 circular count", xfer_count, (i + 1) % 3);
            chk("R8 stays active", status_state, 2'd1);
            if (i == 2) chk("R8 wrap complete flag", status_flags[2], 1'b1);
        end
        cfg_enable = 1'b0;
        step();
        chk("R10 disable while waiting", status_state, 2'd0);
        chk("R10 disabled flag no request", status_flags[3], 1'b1);
        clear_all();

        // Disable in the middle of a word
        cfg_len = 8'd4; cfg_circular = 1'b0; cfg_enable = 1'b1;
        step();
        do_word(32'hDEAD_BEEF, BASE, 2, 1, 1'b1);
        chk("R9 idle after in-flight word", status_state, 2'd0);
        chk("R9 flags start counter disabled", status_flags, 4'b1011);
        chk("R9 word counted", xfer_count, 1);
        periph_req = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R9 request ignored", {pbus_req, mem_req}, 2'b00);
        end
        periph_req = 1'b0;
        clear_all();

        // Flag masking
        irq_en = 4'b0001; cfg_len = 8'd1; cfg_enable = 1'b1;
        step();
        do_word(32'h0000_1234, BASE, 0, 0, 1'b0);
        chk("R11 masked flags", status_flags, 4'b0001);
        chk("R7 complete with mask", status_state, 2'd2);
        cfg_enable = 1'b0;
        step();
        chk("R11 disabled masked", status_flags, 4'b0001);
        chk("R11 irq output", irq, 1'b1);
        flag_clr = 4'b0001;
        step();
        flag_clr = 4'b0000;
        chk("R11 clear start", status_flags, 4'b0000);

        // Partial clear and set-wins
        irq_en = 4'hF; cfg_len = 8'd0; cfg_enable = 1'b1;
        step();
        chk("R2 zero length again", status_flags, 4'b0101);
        flag_clr = 4'b0100;
        step();
        flag_clr = 4'b0000;
        chk("R11 partial clear", status_flags, 4'b0001);
        cfg_enable = 1'b0;
        flag_clr = 4'b1000;
        step();
        flag_clr = 4'b0000;
        chk("R11 set wins over clear", status_flags, 4'b1001);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule